// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Detector

This block takes the crystal reference clock of a tuning synthesizer (3.2 or 4.0 MHz in the intended use) and divides it by one of two ratios, 512 or 1024, to make the comparison rate. Each completed reference period yields a one-cycle pulse. That pulse is compared against the feedback pulse from the programmable loop divider by a phase-frequency detector. The detector drives two charge-pump enables: one raises the tuning voltage and one lowers it.

Two control bits choose the detector mode. In normal mode it performs phase-frequency detection. Three override modes exist: both pump outputs released to high impedance, the raising source forced on alone, or the lowering source forced on alone. A separate select bit picks the low (about 40 µA) or high (about 125 µA) pump current. This bit is passed to the analog pump as a plain digital line. The analog charge pump and the loop filter lie outside this block.

All control pins are plain levels. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `ref_phase_cmp`

## Requirements
- R1: With `ratio_sel` equal to 2'b00 or 2'b11, successive `ref_pulse` assertions are 512 clock cycles apart.
- R2: With `ratio_sel` equal to 2'b01 or 2'b10 (the two bits differ), successive `ref_pulse` assertions are 1024 clock cycles apart.
- R3: The divider samples `ratio_sel` only in the cycle where `ref_pulse` is high. A change made partway through a period leaves the length of that period unchanged and applies from the following period.
- R4: `ref_pulse` is high for exactly one clock cycle per reference period.
- R5: With `det_mode` = 2'b10 (normal), a reference pulse sets `pump_up` on the next clock and a feedback rising edge sets `pump_dn` on the next clock. Each stays set until the overlap clear of R6.
- R6: In normal mode, once `pump_up` and `pump_dn` are both high, both go low on the following clock.
- R7: `pump_dn` is set only by a 0-to-1 transition of `fb_pulse`. Holding `fb_pulse` high does not set it again.
- R8: With `det_mode` = 2'b11 (high impedance), `pump_up`, `pump_dn` and `pump_oe` are all low. In every other mode `pump_oe` is high.
- R9: With `det_mode` = 2'b00, `pump_up` is high and `pump_dn` is low, whatever the reference and feedback pulses do.
- R10: With `det_mode` = 2'b01, `pump_dn` is high and `pump_up` is low.
- R11: While any override mode (R8 to R10) is selected, the detector state is held cleared. On a return to normal mode, both enables start low.
- R12: `pump_hi_cur` follows `cur_sel`: 0 selects low pump current and 1 selects high pump current.
- R13: After reset, `pump_up` and `pump_dn` are low and `ref_pulse` is low. The first period always uses ratio 512, so the first `ref_pulse` appears on the 511th clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock from the crystal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Reference ratio code; equal bits give 512, differing bits give 1024 |
| det_mode | input | 2 | Detector mode: 10 normal, 11 high impedance, 00 up only, 01 down only |
| cur_sel | input | 1 | Pump current choice: 0 low, 1 high |
| fb_pulse | input | 1 | Programmable divider output, synchronous to `clk` |
| pump_up | output | 1 | Enable for the raising current source |
| pump_dn | output | 1 | Enable for the lowering current source |
| pump_oe | output | 1 | Pump output enable; low means high impedance |
| pump_hi_cur | output | 1 | Current-level select line to the analog pump |
| ref_pulse | output | 1 | One-cycle pulse at the comparison frequency |

## Verification
The assertions assume that `fb_pulse` is synchronous to `clk`. They also assume that both ratios are at least two, so reference pulses can never fall on adjacent cycles. The hold property for `pump_up` further assumes that a feedback rising edge is the only thing that sets `pump_dn`. The bench changes every input on the falling clock edge. It places feedback pulses well away from reference pulses, except where a coincidence is the point of the test. It changes `ratio_sel` either in the cycle of a reference pulse or far from one.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
  typedef enum logic [1:0] {
    DET_UP_ONLY = 2'b00,
    DET_DN_ONLY = 2'b01,
    DET_NORMAL  = 2'b10,
    DET_HIZ     = 2'b11
  } det_mode_e;
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int RATIO_LO = 512,
  parameter int RATIO_HI = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  output logic       ref_tick
);
  localparam int CNT_W = $clog2(RATIO_HI);
  localparam logic [CNT_W-1:0] LOAD_LO = CNT_W'(RATIO_LO - 1);
  localparam logic [CNT_W-1:0] LOAD_HI = CNT_W'(RATIO_HI - 1);

  logic [CNT_W-1:0] cnt;
  logic             use_hi;
  logic             want_hi;

  // differing code bits pick the long ratio
  assign want_hi  = ratio_sel[1] ^ ratio_sel[0];
  assign ref_tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= LOAD_LO;
      use_hi <= 1'b0;
    end else if (ref_tick) begin
      cnt    <= want_hi ? LOAD_HI : LOAD_LO;
      use_hi <= want_hi;
    end else begin
      cnt    <= cnt - 1'b1;
    end
  end

  // R3: the active ratio only moves at a terminal count
  assert_ratio_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(use_hi));
  // R3: count never exceeds the load of the active ratio
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (use_hi ? LOAD_HI : LOAD_LO));
  // R4: a pulse is never followed by another pulse
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_ev,
  input  logic fb_lvl,
  output logic up,
  output logic dn
);
  logic fb_q;
  logic fb_ev;

  assign fb_ev = fb_lvl & ~fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q <= 1'b0;
      up   <= 1'b0;
      dn   <= 1'b0;
    end else begin
      fb_q <= fb_lvl;
      if (!run) begin
        up <= 1'b0;
        dn <= 1'b0;
      end else if (up && dn) begin
        up <= 1'b0;
        dn <= 1'b0;
      end else begin
        if (ref_ev) up <= 1'b1;
        if (fb_ev)  dn <= 1'b1;
      end
    end
  end

  // R6: overlap clears both next cycle
  assert_overlap_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> (!up && !dn));
  // R5: a lone up stays set while running
  assert_up_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && run) |=> up);
  // R11: overrides keep detector state cleared
  assert_override_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!up && !dn));
  // R7: dn can rise only after a feedback rising edge
  assert_dn_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(fb_lvl && !fb_q));
endmodule

// File: rtl/pump_mode_ctrl.sv
module pump_mode_ctrl
  import refcmp_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       pfd_up,
  input  logic       pfd_dn,
  output logic       run,
  output logic       up,
  output logic       dn,
  output logic       oe
);
  det_mode_e m;
  assign m = det_mode_e'(mode);

  always_comb begin
    run = 1'b0;
    up  = 1'b0;
    dn  = 1'b0;
    oe  = 1'b1;
    case (m)
      DET_NORMAL: begin
        run = 1'b1;
        up  = pfd_up;
        dn  = pfd_dn;
      end
      DET_UP_ONLY: up = 1'b1;
      DET_DN_ONLY: dn = 1'b1;
      default:     oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/ref_phase_cmp.sv
module ref_phase_cmp #(
  parameter int RATIO_LO = 512,
  parameter int RATIO_HI = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic [1:0] det_mode,
  input  logic       cur_sel,
  input  logic       fb_pulse,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       pump_oe,
  output logic       pump_hi_cur,
  output logic       ref_pulse
);
  logic tick;
  logic run;
  logic core_up;
  logic core_dn;

  ref_divider #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) i_div (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .ref_tick(tick)
  );

  pfd_core i_pfd (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_ev(tick),
    .fb_lvl(fb_pulse), .up(core_up), .dn(core_dn)
  );

  pump_mode_ctrl i_mode (
    .mode(det_mode), .pfd_up(core_up), .pfd_dn(core_dn),
    .run(run), .up(pump_up), .dn(pump_dn), .oe(pump_oe)
  );

  assign ref_pulse   = tick;
  assign pump_hi_cur = cur_sel;

  // R8: a released pump never has an enable on
  assert_hiz_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_oe |-> (!pump_up && !pump_dn));
  // R9: forcing up never drives down
  assert_force_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_mode == 2'b00) |-> (pump_up && !pump_dn && pump_oe));
  // R10: forcing down never drives up
  assert_force_dn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (det_mode == 2'b01) |-> (pump_dn && !pump_up && pump_oe));
endmodule

// File: tb/test_ref_phase_cmp.sv
module test_ref_phase_cmp;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic [1:0] det_mode = 2'b10;
  logic       cur_sel = 1'b0;
  logic       fb_pulse = 1'b0;
  logic       pump_up, pump_dn, pump_oe, pump_hi_cur, ref_pulse;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_phase_cmp i_ref_phase_cmp (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .det_mode(det_mode),
    .cur_sel(cur_sel), .fb_pulse(fb_pulse), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_oe(pump_oe), .pump_hi_cur(pump_hi_cur),
    .ref_pulse(ref_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pump(input string req, input int up, input int dn, input int oe);
    check({req, " up"}, int'(pump_up), up);
    check({req, " dn"}, int'(pump_dn), dn);
    check({req, " oe"}, int'(pump_oe), oe);
  endtask

  task automatic sync_tick();
    do @(negedge clk); while (!ref_pulse);
  endtask

  task automatic count_to_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_pulse && n < 5000);
  endtask

  task automatic t_reset();
    int n;
    check("R13 up at reset", int'(pump_up), 0);
    check("R13 dn at reset", int'(pump_dn), 0);
    check("R13 pulse at reset", int'(ref_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    count_to_tick(n);
    check("R13 first pulse delay", n, 511);
  endtask

  task automatic t_ratio(input logic [1:0] sel, input int exp, input string req);
    int n;
    sync_tick();
    ratio_sel = sel;
    @(negedge clk);
    check({req, " pulse width"}, int'(ref_pulse), 0);  // R4
    count_to_tick(n);
    check({req, " period"}, n + 1, exp);
  endtask

  task automatic t_midchange();
    int n;
    sync_tick();
    ratio_sel = 2'b00;
    repeat (100) @(negedge clk);
    ratio_sel = 2'b01;
    count_to_tick(n);
    check("R3 period after mid change", n + 100, 512);
    count_to_tick(n);
    check("R3 following period", n, 1024);
  endtask

  task automatic t_pfd_ref_first();
    det_mode = 2'b11;
    repeat (2) @(negedge clk);
    det_mode = 2'b10;
    sync_tick();
    check_pump("R11 clean at pulse", 0, 0, 1);
    @(negedge clk);
    check_pump("R5 ref sets up", 1, 0, 1);
    fb_pulse = 1'b1;
    @(negedge clk);
    check_pump("R5 fb sets dn", 1, 1, 1);
    @(negedge clk);
    check_pump("R6 overlap clears", 0, 0, 1);
    repeat (3) @(negedge clk);
    check("R7 held fb no retrigger", int'(pump_dn), 0);
    fb_pulse = 1'b0;
  endtask

  task automatic t_pfd_fb_first();
    repeat (20) @(negedge clk);
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    check_pump("R5 fb first", 0, 1, 1);
    repeat (30) @(negedge clk);
    check_pump("R5 dn holds", 0, 1, 1);
    sync_tick();
    @(negedge clk);
    check_pump("R6 overlap after ref", 1, 1, 1);
    @(negedge clk);
    check_pump("R6 cleared", 0, 0, 1);
  endtask

  task automatic t_modes();
    det_mode = 2'b00;
    @(negedge clk);
    check_pump("R9 up only", 1, 0, 1);
    sync_tick();
    @(negedge clk);
    check_pump("R9 up only across pulse", 1, 0, 1);
    det_mode = 2'b01;
    @(negedge clk);
    check_pump("R10 dn only", 0, 1, 1);
    det_mode = 2'b11;
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    @(negedge clk);
    check_pump("R8 high impedance", 0, 0, 0);
    det_mode = 2'b10;
    @(negedge clk);
    check_pump("R11 back to normal", 0, 0, 1);
  endtask

  task automatic t_current();
    cur_sel = 1'b1;
    @(negedge clk);
    check("R12 high current", int'(pump_hi_cur), 1);
    cur_sel = 1'b0;
    @(negedge clk);
    check("R12 low current", int'(pump_hi_cur), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    t_reset();
    t_ratio(2'b00, 512, "R1 code 00");
    t_ratio(2'b11, 512, "R1 code 11");
    t_ratio(2'b01, 1024, "R2 code 01");
    t_ratio(2'b10, 1024, "R2 code 10");
    t_midchange();
    t_pfd_ref_first();
    t_pfd_fb_first();
    t_modes();
    t_current();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule